// File: doc/BRIEF.md
# Processor control status register

This block is the 32-bit control and status word of a small processor core. Software reaches it through the core's control-register move path. A read returns the whole word in one cycle. A write updates the fields that software may change. The word carries:

- two identification bytes fixed at build time;
- a power-down request field that software can write but always reads as zero;
- program and data cache mode fields;
- a sticky saturation flag;
- an endianness status bit;
- a global interrupt enable, together with a saved copy of that enable.

The functional units report saturation events. Each event comes with a qualifier that says whether the instruction's condition held. A qualified event sets the saturation flag one full cycle later. Only a software write of zero to that bit clears the flag, and a hardware set that lands in the same cycle as such a clear wins. The interrupt controller signals two things: an interrupt being taken, which saves the enable and clears it, and a return from interrupt, which restores the enable. The block drives a mask line to the interrupt logic. Reset and the non-maskable interrupt are handled outside this block and are never masked by it.

Top module: `ctrl_status_reg`

## Requirements
- R1: After reset, the readback holds zero in bits 15..0 except bit 8, and bits 31..16 hold the identification parameters. The mode outputs read zero and maskInts is 1.
- R2: Bits 31..24 always read CORE_ID and bits 23..16 always read REV_ID. Software writes never change them.
- R3: A write stores bits 15..10 of the write data. The stored value drives pwrdMode from the next cycle on, but bits 15..10 of the readback are always zero.
- R4: A write stores bits 7..5 as the program cache mode and bits 4..2 as the data cache mode. Both read back in place and drive pccMode and dccMode from the next cycle on.
- R5: A saturation event whose qualifier is 1, on any unit, is sampled at clock edge k. Bit 9 (the saturation flag) reads 1 after edge k+1, and still reads 0 between edges k and k+1.
- R6: A saturation event whose qualifier is 0 never changes bit 9.
- R7: A software write with bit 9 = 0 clears the flag at the next edge. A write with bit 9 = 1 leaves the flag unchanged, so software can never set it.
- R8: When a delayed hardware set and a software clear of bit 9 reach the same edge, bit 9 ends up 1.
- R9: On interrupt taken, bit 1 receives the old bit 0 and bit 0 becomes 0. This overrides a software write to bits 1..0 in the same cycle.
- R10: On return from interrupt with no interrupt taken in the same cycle, bit 0 receives the old bit 1. The interrupt-taken action has priority over return.
- R11: Bit 8 always equals the endianLittle input (1 = little, 0 = big). Software writes to bit 8 have no effect.
- R12: maskInts equals the inverse of bit 0 of the readback: maskable interrupts are blocked while bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWrEn | input | 1 | Software write strobe from the control-register move path |
| swWrData | input | 32 | Software write data |
| swRdData | output | 32 | Current register value for software reads |
| satEvent | input | NUM_UNITS | Saturation event, one per functional unit |
| satCondOk | input | NUM_UNITS | Per-unit qualifier: the instruction's condition held |
| intTaken | input | 1 | An interrupt is being taken this cycle |
| intReturn | input | 1 | A return from interrupt happens this cycle |
| endianLittle | input | 1 | Device endianness strap, 1 = little endian |
| pwrdMode | output | 6 | Stored power-down request field |
| pccMode | output | 3 | Program cache mode |
| dccMode | output | 3 | Data cache mode |
| maskInts | output | 1 | 1 while maskable interrupts are disabled |

## Verification
Directed cases cover the order-sensitive corners:
- a qualified event and an unqualified event, which separate qualification from plain event detection;
- a write of all ones, which shows that software cannot set the flag and that the identification and power-down fields are read-only on the read path;
- a clear placed exactly on the edge of a delayed set, which shows which side has priority;
- an interrupt taken together with a conflicting write, and a return taken together with a write, which show the priority between the interrupt actions and software.

Seeded random traffic then mixes:
- events on several units at once;
- random qualifiers;
- overlapping writes;
- simultaneous take and return;
- toggling endianness.

Every cycle is compared against a bench reference model, which shows up any mistake in the one-cycle delay or in the priority order that the directed cases do not reach.

// File: rtl/ctrl_status_pkg.sv
package ctrl_status_pkg;

  localparam int CSR_W      = 32;
  localparam int PWRD_W     = 6;
  localparam int CACHE_W    = 3;
  localparam int ID_W       = 8;

  // Bit positions software depends on
  localparam int GIE_BIT    = 0;
  localparam int PGIE_BIT   = 1;
  localparam int DCC_LSB    = 2;
  localparam int PCC_LSB    = 5;
  localparam int EN_BIT     = 8;
  localparam int SAT_BIT    = 9;
  localparam int PWRD_LSB   = 10;
  localparam int REV_LSB    = 16;
  localparam int CORE_LSB   = 24;

  typedef struct packed {
    logic wrFields;    // software write of writable fields
    logic clrSat;      // software clear of saturation flag
    logic setSat;      // delayed hardware set of saturation flag
    logic saveGie;     // interrupt taken: save and clear enable
    logic restoreGie;  // return from interrupt: restore enable
  } csrStrobes_t;

endpackage

// File: rtl/ctrl_status_ctl.sv
module ctrl_status_ctl
  import ctrl_status_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swWrEn,
  input  logic                 swWrSatBit,
  input  logic [NUM_UNITS-1:0] satEvent,
  input  logic [NUM_UNITS-1:0] satCondOk,
  input  logic                 intTaken,
  input  logic                 intReturn,
  output csrStrobes_t          strobes
);

  logic [NUM_UNITS-1:0] qualVec;
  logic                 anySat;
  logic                 satPend;

  // One qualifier gate per functional unit
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_qual
    assign qualVec[u] = satEvent[u] & satCondOk[u];
  end

  assign anySat = |qualVec;

  // One-cycle delay between a saturation event and the flag update
  always_ff @(posedge clk) begin
    if (!rstN) satPend <= 1'b0;
    else       satPend <= anySat;
  end

  always_comb begin
    strobes            = '0;
    strobes.wrFields   = swWrEn;
    strobes.clrSat     = swWrEn & ~swWrSatBit;
    strobes.setSat     = satPend;
    strobes.saveGie    = intTaken;
    strobes.restoreGie = intReturn & ~intTaken;
  end

  AST_SAT_DELAYED: assert property (@(posedge clk) disable iff (!rstN)
    anySat |=> strobes.setSat) else $error("qualified event not forwarded"); // R5

  AST_UNQUAL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    ((satEvent & satCondOk) == '0) |=> !strobes.setSat) else $error("unqualified event set flag"); // R6

  AST_TAKE_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |-> !strobes.restoreGie) else $error("return acted during take"); // R10

endmodule

// File: rtl/ctrl_status_dp.sv
module ctrl_status_dp
  import ctrl_status_pkg::*;
#(
  parameter logic [ID_W-1:0] CORE_ID = 8'h00,
  parameter logic [ID_W-1:0] REV_ID  = 8'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobes_t         strobes,
  input  logic [CSR_W-1:0]    swWrData,
  input  logic                endianLittle,
  output logic [CSR_W-1:0]    rdData,
  output logic [PWRD_W-1:0]   pwrdMode,
  output logic [CACHE_W-1:0]  pccMode,
  output logic [CACHE_W-1:0]  dccMode,
  output logic                gieOut
);

  logic                satQ;
  logic                gieQ;
  logic                pgieQ;
  logic [PWRD_W-1:0]   pwrdQ;
  logic [CACHE_W-1:0]  pccQ;
  logic [CACHE_W-1:0]  dccQ;

  // Mode fields: plain software-written storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrdQ <= '0;
      pccQ  <= '0;
      dccQ  <= '0;
    end else if (strobes.wrFields) begin
      pwrdQ <= swWrData[PWRD_LSB +: PWRD_W];
      pccQ  <= swWrData[PCC_LSB +: CACHE_W];
      dccQ  <= swWrData[DCC_LSB +: CACHE_W];
    end
  end

  // Sticky saturation flag: hardware set wins over software clear
  always_ff @(posedge clk) begin
    if (!rstN)               satQ <= 1'b0;
    else if (strobes.setSat) satQ <= 1'b1;
    else if (strobes.clrSat) satQ <= 1'b0;
  end

  // Interrupt enable and its saved copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieQ  <= 1'b0;
      pgieQ <= 1'b0;
    end else if (strobes.saveGie) begin
      pgieQ <= gieQ;
      gieQ  <= 1'b0;
    end else begin
      if (strobes.restoreGie)    gieQ <= pgieQ;
      else if (strobes.wrFields) gieQ <= swWrData[GIE_BIT];
      if (strobes.wrFields)      pgieQ <= swWrData[PGIE_BIT];
    end
  end

  always_comb begin
    rdData                         = '0;
    rdData[CORE_LSB +: ID_W]       = CORE_ID;
    rdData[REV_LSB +: ID_W]        = REV_ID;
    rdData[SAT_BIT]                = satQ;
    rdData[EN_BIT]                 = endianLittle;
    rdData[PCC_LSB +: CACHE_W]     = pccQ;
    rdData[DCC_LSB +: CACHE_W]     = dccQ;
    rdData[PGIE_BIT]               = pgieQ;
    rdData[GIE_BIT]                = gieQ;
  end

  assign pwrdMode = pwrdQ;
  assign pccMode  = pccQ;
  assign dccMode  = dccQ;
  assign gieOut   = gieQ;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setSat |=> satQ) else $error("set lost"); // R8

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satQ) |-> $past(strobes.setSat)) else $error("flag set without event"); // R7

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.setSat && !strobes.clrSat) |=> $stable(satQ)) else $error("flag changed"); // R7

  AST_SAVE_GIE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.saveGie |=> (pgieQ == $past(gieQ)) && !gieQ) else $error("save failed"); // R9

  AST_RESTORE_GIE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restoreGie |=> gieQ == $past(pgieQ)) else $error("restore failed"); // R10

endmodule

// File: rtl/ctrl_status_reg.sv
module ctrl_status_reg
  import ctrl_status_pkg::*;
#(
  parameter logic [7:0] CORE_ID   = 8'h00,
  parameter logic [7:0] REV_ID    = 8'h01,
  parameter int         NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swWrEn,
  input  logic [31:0]          swWrData,
  output logic [31:0]          swRdData,
  input  logic [NUM_UNITS-1:0] satEvent,
  input  logic [NUM_UNITS-1:0] satCondOk,
  input  logic                 intTaken,
  input  logic                 intReturn,
  input  logic                 endianLittle,
  output logic [5:0]           pwrdMode,
  output logic [2:0]           pccMode,
  output logic [2:0]           dccMode,
  output logic                 maskInts
);

  csrStrobes_t strobes;
  logic        gieOut;

  ctrl_status_ctl #(.NUM_UNITS(NUM_UNITS)) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .swWrEn     (swWrEn),
    .swWrSatBit (swWrData[SAT_BIT]),
    .satEvent   (satEvent),
    .satCondOk  (satCondOk),
    .intTaken   (intTaken),
    .intReturn  (intReturn),
    .strobes    (strobes)
  );

  ctrl_status_dp #(.CORE_ID(CORE_ID), .REV_ID(REV_ID)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .swWrData     (swWrData),
    .endianLittle (endianLittle),
    .rdData       (swRdData),
    .pwrdMode     (pwrdMode),
    .pccMode      (pccMode),
    .dccMode      (dccMode),
    .gieOut       (gieOut)
  );

  assign maskInts = ~gieOut;

  AST_MASK_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    maskInts == ~swRdData[GIE_BIT]) else $error("mask mismatch"); // R12

  AST_PWRD_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    swRdData[15:10] == 6'd0) else $error("power-down field readable"); // R3

endmodule

// File: tb/ctrl_status_reg_tb_top.sv
`timescale 1ns/1ps
module ctrl_status_reg_tb_top;

  localparam logic [7:0] CID = 8'h02;
  localparam logic [7:0] RID = 8'h5A;
  localparam int         NU  = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          swWrEn;
  logic [31:0]   swWrData;
  logic [31:0]   swRdData;
  logic [NU-1:0] satEvent;
  logic [NU-1:0] satCondOk;
  logic          intTaken;
  logic          intReturn;
  logic          endianLittle;
  logic [5:0]    pwrdMode;
  logic [2:0]    pccMode;
  logic [2:0]    dccMode;
  logic          maskInts;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic       mPend, mSat, mGie, mPgie;
  logic [5:0] mPwrd;
  logic [2:0] mPcc, mDcc;

  always #2 clk = ~clk;

  ctrl_status_reg #(.CORE_ID(CID), .REV_ID(RID), .NUM_UNITS(NU)) dut_i (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .swRdData(swRdData), .satEvent(satEvent), .satCondOk(satCondOk),
    .intTaken(intTaken), .intReturn(intReturn), .endianLittle(endianLittle),
    .pwrdMode(pwrdMode), .pccMode(pccMode), .dccMode(dccMode),
    .maskInts(maskInts)
  );

  function automatic logic [31:0] expRead();
    return {CID, RID, 6'd0, mSat, endianLittle, mPcc, mDcc, mPgie, mGie};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic q, nSat, nGie, nPgie;
    q    = |(satEvent & satCondOk);
    nSat = mPend ? 1'b1 : ((swWrEn && !swWrData[9]) ? 1'b0 : mSat);
    nGie = mGie; nPgie = mPgie;
    if (intTaken) begin
      nPgie = mGie; nGie = 1'b0;
    end else begin
      if (intReturn)   nGie = mPgie;
      else if (swWrEn) nGie = swWrData[0];
      if (swWrEn)      nPgie = swWrData[1];
    end
    if (swWrEn) begin
      mPwrd = swWrData[15:10]; mPcc = swWrData[7:5]; mDcc = swWrData[4:2];
    end
    mPend = q; mSat = nSat; mGie = nGie; mPgie = nPgie;
  endtask

  // Drive one cycle of inputs at a falling edge, check after the next rising edge
  task automatic cyc(input logic wr, input logic [31:0] d, input logic [NU-1:0] ev,
                     input logic [NU-1:0] ok, input logic tk, input logic rt, input string tag);
    swWrEn = wr; swWrData = d; satEvent = ev; satCondOk = ok;
    intTaken = tk; intReturn = rt;
    modelStep();
    @(negedge clk);
    chk(tag, swRdData, expRead());
    chk("R3 pwrdMode", {26'd0, pwrdMode}, {26'd0, mPwrd});
    chk("R4 cache outputs", {26'd0, pccMode, dccMode}, {26'd0, mPcc, mDcc});
    chk("R12 maskInts", {31'd0, maskInts}, {31'd0, ~mGie});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; swWrEn = 0; swWrData = '0; satEvent = '0; satCondOk = '0;
    intTaken = 0; intReturn = 0; endianLittle = 1'b1;
    mPend = 0; mSat = 0; mGie = 0; mPgie = 0; mPwrd = '0; mPcc = '0; mDcc = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 reset readback", swRdData, {CID, RID, 16'h0100});
    chk("R1 reset outputs", {20'd0, pwrdMode, pccMode, dccMode}, 32'd0);
    chk("R1 reset mask", {31'd0, maskInts}, 32'd1);

    // R2 R3 R4 R7 R11: all-ones write; IDs, power-down readback, EN, SAT untouched
    cyc(1, 32'hFFFF_FFFF, '0, '0, 0, 0, "R2 R7 R11 all-ones write");
    chk("R2 id bytes", swRdData[31:16], {CID, RID});
    chk("R3 pwrd reads zero", {26'd0, swRdData[15:10]}, 32'd0);
    chk("R4 pcc dcc", {26'd0, swRdData[7:2]}, 32'h3F);
    chk("R7 sw cannot set", {31'd0, swRdData[9]}, 32'd0);

    // R6: unqualified events
    cyc(0, '0, 4'hF, 4'h0, 0, 0, "R6 event cond false");
    cyc(0, '0, '0, '0, 0, 0, "R6 no set after false cond");
    chk("R6 sat stays 0", {31'd0, swRdData[9]}, 32'd0);

    // R5: qualified event on unit 2 only
    cyc(0, '0, 4'b0100, 4'b0100, 0, 0, "R5 event edge");
    chk("R5 not yet visible", {31'd0, swRdData[9]}, 32'd0);
    cyc(0, '0, '0, '0, 0, 0, "R5 one cycle later");
    chk("R5 visible", {31'd0, swRdData[9]}, 32'd1);

    // R7: write bit9=1 keeps, bit9=0 clears
    cyc(1, 32'h0000_0200, '0, '0, 0, 0, "R7 write one keeps");
    chk("R7 kept", {31'd0, swRdData[9]}, 32'd1);
    cyc(1, 32'h0000_0000, '0, '0, 0, 0, "R7 write zero clears");
    chk("R7 cleared", {31'd0, swRdData[9]}, 32'd0);

    // R8: clear lands on the same edge as the delayed set
    cyc(0, '0, 4'b0001, 4'b0001, 0, 0, "R8 event");
    cyc(1, 32'h0000_0000, '0, '0, 0, 0, "R8 clear vs set");
    chk("R8 set wins", {31'd0, swRdData[9]}, 32'd1);

    // R9: enable, then take an interrupt alongside a conflicting write
    cyc(1, 32'h0000_0001, '0, '0, 0, 0, "R12 enable gie");
    chk("R12 unmasked", {31'd0, maskInts}, 32'd0);
    cyc(1, 32'h0000_0001, '0, '0, 1, 0, "R9 take overrides write");
    chk("R9 pgie gie", {30'd0, swRdData[1:0]}, 32'd2);
    chk("R12 masked after take", {31'd0, maskInts}, 32'd1);

    // R10: return restores; take has priority over return
    cyc(0, '0, '0, '0, 1, 1, "R10 take beats return");
    chk("R10 both zero", {30'd0, swRdData[1:0]}, 32'd0);
    cyc(1, 32'h0000_0002, '0, '0, 0, 0, "R10 set pgie");
    cyc(0, '0, '0, '0, 0, 1, "R10 return restores");
    chk("R10 gie restored", {31'd0, swRdData[0]}, 32'd1);

    // R11: endianness follows input only
    endianLittle = 1'b0;
    cyc(1, 32'h0000_0100, '0, '0, 0, 0, "R11 big endian");
    chk("R11 en bit", {31'd0, swRdData[8]}, 32'd0);

    // Random traffic against the model (R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      logic wr, tk, rt;
      logic [NU-1:0] ev, ok;
      wr = ($urandom % 4) == 0;
      ev = NU'($urandom);
      ok = NU'($urandom);
      if (($urandom % 3) != 0) ev = '0;
      tk = ($urandom % 8) == 0;
      rt = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) endianLittle = ~endianLittle;
      cyc(wr, $urandom, ev, ok, tk, rt, "R5 R7 R8 R9 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule